// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Array

This block is one output cell that sits behind a programmable AND/OR array. It takes the OR sum of the cell's product terms and routes it to a pin. It can route the sum through a D flip-flop or pass it straight through. Either way, a polarity bit can invert it before it reaches the pin. A product term of its own gates the pin driver. A signal goes back into the array as feedback. In registered mode that signal is the flip-flop state, and in combinational mode it is the level seen at the pin. A cell whose driver is never enabled therefore behaves as a dedicated input.

Two terms shared by all cells act on the flip-flop state and not on the pin. One is an asynchronous clear. The other is a set that takes effect on the next clock edge. A test preload mode disables the driver and loads the flip-flop from the pin level on a rising clock edge, so a state machine can be placed directly into any state. The flip-flop is held LOW by the power-up reset.

The flip-flop is modelled as a two-state machine. Its states are `ST_LOW` and `ST_HIGH`. Its clocked transitions are `TR_LOAD_PIN` (preload), `TR_SET` (synchronous preset) and `TR_CAPTURE` (normal capture of the sum). An asynchronous forced entry into `ST_LOW` comes from the power-up reset or the clear term.

Top module: `mc_macrocell`

## Requirements
- R1: While `rst_n` is low the flip-flop state is LOW. In registered mode this gives `fb_out` = 0 and a pin level of 0 (active-high) or 1 (active-low).
- R2: With `preload_en`, `spreset_term` and `areset_term` all low, a rising clock edge loads `sum_term` into the flip-flop.
- R3: With `spreset_term` high and `preload_en` low at a rising edge, the flip-flop becomes HIGH whatever `sum_term` is.
- R4: `areset_term` high forces the flip-flop LOW at once, without a clock edge. It overrides preload, preset and capture for as long as it is high.
- R5: With `preload_en` high, `pin_oe` is 0. A rising edge loads `pin_in` into the flip-flop, and this takes priority over the synchronous preset.
- R6: With `cfg_comb` = 0 (registered), `pin_out` is derived from the flip-flop state and `fb_out` equals the flip-flop state.
- R7: With `cfg_comb` = 1 (combinational), `pin_out` follows `sum_term` with no clock delay and `fb_out` equals `pin_in`.
- R8: With `cfg_high` = 1 the pin level equals the selected value, and with `cfg_high` = 0 it is the inverse. This holds in both modes and after a preset or a clear.
- R9: Outside preload, `pin_oe` equals `oe_term`. With `oe_term` held 0 in combinational mode, `fb_out` still tracks `pin_in` (dedicated-input use).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flip-flop updates on the rising edge |
| rst_n | input | 1 | Power-up reset, active low, clears the flip-flop |
| sum_term | input | 1 | OR sum of the cell's product terms |
| oe_term | input | 1 | Output-enable product term |
| areset_term | input | 1 | Shared asynchronous clear term, active high |
| spreset_term | input | 1 | Shared synchronous preset term, active high |
| cfg_comb | input | 1 | Mode bit: 0 registered, 1 combinational |
| cfg_high | input | 1 | Polarity bit: 1 active-high, 0 active-low |
| preload_en | input | 1 | Test preload mode enable |
| pin_in | input | 1 | Level observed at the pad |
| pin_out | output | 1 | Level to be driven on the pad |
| pin_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback returned to the array |

## Verification
The combinational results are due in the same cycle as their inputs: `pin_oe`, the pin level in combinational mode, the feedback in combinational mode, and the polarity inversion. The bench samples them 1 ns after it drives inputs, without any clock edge in between. Capture, preset and preload each go through the single state register. They are due one rising edge later, and the bench samples them 1 ns after that edge, with the inputs driven at the falling edge before it. The asynchronous clear is checked 1 ns after the term rises, in the middle of a clock phase, which shows that it does not wait for an edge.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } mc_state_e;

    typedef enum logic [1:0] {
        TR_CAPTURE  = 2'd0,
        TR_SET      = 2'd1,
        TR_LOAD_PIN = 2'd2
    } mc_trans_e;

    typedef struct packed {
        logic comb_path;
        logic active_high;
    } mc_cfg_t;

    function automatic logic apply_polarity(input logic val, input logic active_high);
        return active_high ? val : ~val;
    endfunction

endpackage

// File: rtl/mc_state_fsm.sv
module mc_state_fsm
    import mc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      areset_term,
    input  logic      spreset_term,
    input  logic      preload_en,
    input  logic      sum_term,
    input  logic      pin_in,
    output mc_state_e state
);

    mc_trans_e trans;
    mc_state_e state_nxt;

    // Clocked transition selection: preload over preset over capture.
    always_comb begin
        if (preload_en)
            trans = TR_LOAD_PIN;
        else if (spreset_term)
            trans = TR_SET;
        else
            trans = TR_CAPTURE;
    end

    always_comb begin
        unique case (trans)
            TR_LOAD_PIN: state_nxt = pin_in   ? ST_HIGH : ST_LOW;
            TR_SET:      state_nxt = ST_HIGH;
            TR_CAPTURE:  state_nxt = sum_term ? ST_HIGH : ST_LOW;
            default:     state_nxt = ST_LOW;
        endcase
    end

    // State register; the clear term and power-up reset enter ST_LOW at once.
    always_ff @(posedge clk or negedge rst_n or posedge areset_term) begin
        if (!rst_n || areset_term)
            state <= ST_LOW;
        else
            state <= state_nxt;
    end

endmodule

// File: rtl/mc_out_path.sv
module mc_out_path
    import mc_pkg::*;
(
    input  mc_cfg_t   cfg,
    input  mc_state_e state,
    input  logic      sum_term,
    input  logic      oe_term,
    input  logic      preload_en,
    input  logic      pin_in,
    output logic      pin_out,
    output logic      pin_oe,
    output logic      fb_out
);

    logic sel_val;
    logic q_val;

    always_comb begin
        q_val   = (state == ST_HIGH);
        sel_val = cfg.comb_path ? sum_term : q_val;
        pin_out = apply_polarity(sel_val, cfg.active_high);
        pin_oe  = oe_term & ~preload_en;
        fb_out  = cfg.comb_path ? pin_in : q_val;
    end

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
    import mc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sum_term,
    input  logic oe_term,
    input  logic areset_term,
    input  logic spreset_term,
    input  logic cfg_comb,
    input  logic cfg_high,
    input  logic preload_en,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic fb_out
);

    mc_cfg_t   cfg;
    mc_state_e state;

    assign cfg.comb_path   = cfg_comb;
    assign cfg.active_high = cfg_high;

    mc_state_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .areset_term  (areset_term),
        .spreset_term (spreset_term),
        .preload_en   (preload_en),
        .sum_term     (sum_term),
        .pin_in       (pin_in),
        .state        (state)
    );

    mc_out_path u_out (
        .cfg        (cfg),
        .state      (state),
        .sum_term   (sum_term),
        .oe_term    (oe_term),
        .preload_en (preload_en),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .fb_out     (fb_out)
    );

endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk (
    input logic clk,
    input logic rst_n,
    input logic sum_term,
    input logic oe_term,
    input logic areset_term,
    input logic spreset_term,
    input logic cfg_comb,
    input logic cfg_high,
    input logic preload_en,
    input logic pin_in,
    input logic pin_out,
    input logic pin_oe,
    input logic fb_out
);

    // R2
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!preload_en && !spreset_term && !areset_term && !cfg_comb)
        |=> (areset_term || cfg_comb || fb_out == $past(sum_term)));

    // R3
    a_r3_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (spreset_term && !preload_en && !areset_term && !cfg_comb)
        |=> (areset_term || cfg_comb || fb_out));

    // R4
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (areset_term && !cfg_comb) |-> !fb_out);

    // R5
    a_r5_preload_oe: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |-> !pin_oe);

    a_r5_preload_load: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !areset_term && !cfg_comb)
        |=> (areset_term || cfg_comb || fb_out == $past(pin_in)));

    // R6 and R8: registered pin level is the feedback state with polarity
    a_r8_reg_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_comb |-> (pin_out == (cfg_high ? fb_out : !fb_out)));

    // R7
    a_r7_comb_fb: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_comb |-> (fb_out == pin_in));

    // R9
    a_r9_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_en |-> (pin_oe == oe_term));

endmodule

bind mc_macrocell mc_macrocell_chk u_chk (.*);

// File: tb/mc_macrocell_tb.sv
`timescale 1ns/1ps
module mc_macrocell_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sum_term = 1'b0, oe_term = 1'b0, areset_term = 1'b0, spreset_term = 1'b0;
    logic cfg_comb = 1'b0, cfg_high = 1'b1, preload_en = 1'b0, pin_in = 1'b0;
    logic pin_out, pin_oe, fb_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    mc_macrocell u_dut (
        .clk(clk), .rst_n(rst_n), .sum_term(sum_term), .oe_term(oe_term),
        .areset_term(areset_term), .spreset_term(spreset_term),
        .cfg_comb(cfg_comb), .cfg_high(cfg_high), .preload_en(preload_en),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    task automatic check(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    task automatic to_neg();
        @(negedge clk);
    endtask

    task automatic t_reset();
        cfg_comb = 1'b0; cfg_high = 1'b1; sum_term = 1'b1;
        edge_step();
        check(fb_out, 1'b0, "R1 fb in reset");
        check(pin_out, 1'b0, "R1 pin active-high in reset");
        cfg_high = 1'b0; #1;
        check(pin_out, 1'b1, "R1 R8 pin active-low in reset");
        to_neg();
        cfg_high = 1'b1; sum_term = 1'b0; rst_n = 1'b1;
    endtask

    task automatic t_capture();
        logic [4:0] pat = 5'b01101;
        for (int i = 0; i < 5; i++) begin
            to_neg();
            sum_term = pat[i];
            edge_step();
            check(fb_out, pat[i], "R2 capture fb");
            check(pin_out, pat[i], "R6 registered pin");
        end
    endtask

    task automatic t_preset();
        to_neg(); sum_term = 1'b0; edge_step();
        check(fb_out, 1'b0, "R2 capture zero");
        to_neg(); spreset_term = 1'b1; #1;
        check(fb_out, 1'b0, "R3 preset waits for edge");
        edge_step();
        check(fb_out, 1'b1, "R3 preset over capture");
        to_neg(); spreset_term = 1'b0;
    endtask

    task automatic t_areset();
        to_neg(); sum_term = 1'b1; edge_step();
        check(fb_out, 1'b1, "R2 set before clear");
        to_neg(); areset_term = 1'b1; spreset_term = 1'b1; #1;
        check(fb_out, 1'b0, "R4 clear without edge");
        edge_step();
        check(fb_out, 1'b0, "R4 clear over preset");
        to_neg(); preload_en = 1'b1; pin_in = 1'b1; spreset_term = 1'b0;
        edge_step();
        check(fb_out, 1'b0, "R4 clear over preload");
        to_neg(); areset_term = 1'b0; preload_en = 1'b0; pin_in = 1'b0; sum_term = 1'b0;
    endtask

    task automatic t_preload();
        to_neg(); oe_term = 1'b1; #1;
        check(pin_oe, 1'b1, "R9 oe follows term");
        preload_en = 1'b1; pin_in = 1'b1; sum_term = 1'b0; #1;
        check(pin_oe, 1'b0, "R5 driver off in preload");
        edge_step();
        check(fb_out, 1'b1, "R5 preload loads pin high");
        to_neg(); pin_in = 1'b0; spreset_term = 1'b1;
        edge_step();
        check(fb_out, 1'b0, "R5 preload over preset");
        to_neg(); preload_en = 1'b0; spreset_term = 1'b0; oe_term = 1'b0;
    endtask

    task automatic t_polarity_reg();
        to_neg(); cfg_high = 1'b0; spreset_term = 1'b1;
        edge_step();
        check(pin_out, 1'b0, "R8 active-low after preset");
        to_neg(); spreset_term = 1'b0; areset_term = 1'b1; #1;
        check(pin_out, 1'b1, "R8 active-low after clear");
        to_neg(); areset_term = 1'b0; cfg_high = 1'b1;
    endtask

    task automatic t_comb();
        to_neg(); cfg_comb = 1'b1; cfg_high = 1'b1; sum_term = 1'b1; pin_in = 1'b0; #1;
        check(pin_out, 1'b1, "R7 comb pin follows sum");
        check(fb_out, 1'b0, "R7 comb fb from pin");
        sum_term = 1'b0; #1;
        check(pin_out, 1'b0, "R7 comb no clock delay");
        cfg_high = 1'b0; #1;
        check(pin_out, 1'b1, "R8 comb active-low");
        pin_in = 1'b1; #1;
        check(fb_out, 1'b1, "R7 fb tracks pin");
    endtask

    task automatic t_dedicated_input();
        to_neg(); oe_term = 1'b0; cfg_comb = 1'b1; sum_term = 1'b1;
        for (int i = 0; i < 4; i++) begin
            pin_in = i[0]; #1;
            check(pin_oe, 1'b0, "R9 driver held off");
            check(fb_out, i[0], "R9 dedicated input fb");
        end
        to_neg(); cfg_comb = 1'b0; cfg_high = 1'b1; pin_in = 1'b0;
    endtask

    initial begin
        t_reset();
        t_capture();
        t_preset();
        t_areset();
        t_preload();
        t_polarity_reg();
        t_comb();
        t_dedicated_input();
        repeat (2) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule